// File: doc/BRIEF.md
# Video Line Clamp Pulse Generator

This block produces one clamp strobe per video line for an analog front end. It watches the horizontal sync input on the pixel clock and detects the end of each sync pulse. It waits a programmable number of pixel clocks after that edge, then holds the clamp strobe high for a programmable number of pixel clocks. The intent is that the strobe covers the black reference level (back porch) that follows sync.

A mode input can hand clamp timing to an outside source instead. In that mode the external clamp input is registered once and sent to the output, and the internal timing settings have no effect on the output. A zero length setting is not a legal value. The block raises it to one pixel, so every line still gets a clamp of at least one pixel.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset, `clamp_out` is 0.
- R2: A line sequence starts only at the end of a sync pulse. With the default polarity parameter (sync active high), this is a 1-to-0 change of `hsync_in`. A 0-to-1 change starts nothing.
- R3: Let edge k be the first rising clock edge that samples `hsync_in` inactive after an active sample. With placement P (8 bits, 1..255) and internal mode, `clamp_out` stays 0 after edges k+1 .. k+P and goes to 1 after edge k+1+P.
- R4: With length setting D in 1..255, `clamp_out` stays 1 for exactly D pixel clocks and then returns to 0.
- R5: A length setting of 0 gives a clamp of exactly 1 pixel clock.
- R6: An end of sync that arrives while a sequence is still in progress (during the wait or the pulse) abandons that sequence. Timing restarts from the new edge, as in R3 and R4.
- R7: When `ext_mode` is 1, `clamp_out` equals the value `ext_clamp_in` had at the previous rising clock edge. Placement, length and sync have no effect on the output in this mode.
- R8: When `ext_mode` is 0, `ext_clamp_in` has no effect on `clamp_out`.
- R9: With placement 0, `clamp_out` goes to 1 after edge k+1, the first clock after the edge that detects the end of sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync, polarity set by parameter |
| place_cfg | input | CNT_W | Pixel clocks from end of sync to start of clamp |
| dur_cfg | input | CNT_W | Clamp length in pixel clocks (0 treated as 1) |
| ext_mode | input | 1 | 1 selects the external clamp source |
| ext_clamp_in | input | 1 | External clamp request |
| clamp_out | output | 1 | Clamp strobe to the analog front end |

## Verification
The assertions assume that `hsync_in` and `ext_clamp_in` are already synchronous to the pixel clock. They also assume that placement is held steady from the end of sync until the sequence either starts its pulse or is restarted, because placement is read only at the edge. The stimulus changes all settings and the mode only on falling clock edges, while no sequence is running or before the next sync pulse ends. The only exception is the restart scenario, which changes just the sync input.

// File: rtl/clamp_pkg.sv
// Shared types for the clamp pulse generator.
package clamp_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_PULSE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/clamp_edge_det.sv
// Detects the end of the sync pulse.
// Assumes hsync_in is synchronous to clk. The parameter gives the active level.
module clamp_edge_det #(
    parameter bit HS_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    output logic trail_o
);
    logic hs_now;
    logic hs_prev;
    logic hs_norm;

    // Fold the polarity so that 1 always means sync active.
    assign hs_norm = HS_ACTIVE_HIGH ? hsync_in : ~hsync_in;

    // Two-stage history of the normalised sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_now  <= 1'b0;
            hs_prev <= 1'b0;
        end else begin
            hs_now  <= hs_norm;
            hs_prev <= hs_now;
        end
    end

    // Active before and inactive now marks the end of sync.
    assign trail_o = hs_prev & ~hs_now;
endmodule

// File: rtl/clamp_seq_timer.sv
// Wait-then-pulse sequencer started by each end-of-sync strobe.
// Assumes place_i is steady while a wait is running. dur_i is captured at the edge.
module clamp_seq_timer
    import clamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trail_i,
    input  logic [CNT_W-1:0] place_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             clamp_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] dur_lat;
    logic [CNT_W-1:0] dur_eff;

    // An illegal zero length is raised to one pixel.
    assign dur_eff = (dur_i == '0) ? ONE : dur_i;

    // Sequencer: an edge always restarts; otherwise count down the wait, then the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            rem     <= '0;
            dur_lat <= ONE;
        end else if (trail_i) begin
            dur_lat <= dur_eff;
            if (place_i == '0) begin
                state <= SEQ_PULSE;
                rem   <= dur_eff - ONE;
            end else begin
                state <= SEQ_DELAY;
                rem   <= place_i - ONE;
            end
        end else begin
            case (state)
                SEQ_DELAY: begin
                    if (rem == '0) begin
                        state <= SEQ_PULSE;
                        rem   <= dur_lat - ONE;
                    end else begin
                        rem <= rem - ONE;
                    end
                end
                SEQ_PULSE: begin
                    if (rem == '0) begin
                        state <= SEQ_IDLE;
                    end else begin
                        rem <= rem - ONE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign clamp_o = (state == SEQ_PULSE);
endmodule

// File: rtl/clamp_out_sel.sv
// Chooses between the internal strobe and the registered external clamp.
// Assumes ext_clamp_in is synchronous to clk.
module clamp_out_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic ext_clamp_in,
    input  logic int_clamp,
    output logic clamp_out
);
    logic ext_q;

    // Single register stage on the external request.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_clamp_in;
    end

    // The mode bit selects the output source.
    assign clamp_out = ext_mode ? ext_q : int_clamp;
endmodule

// File: rtl/clamp_pulse_gen.sv
// Top: per-line clamp strobe timed from the end of horizontal sync.
// Assumes every input is synchronous to the pixel clock.
module clamp_pulse_gen #(
    parameter int CNT_W          = 8,
    parameter bit HS_ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic [CNT_W-1:0] place_cfg,
    input  logic [CNT_W-1:0] dur_cfg,
    input  logic             ext_mode,
    input  logic             ext_clamp_in,
    output logic             clamp_out
);
    logic trail_w;
    logic clamp_int_w;

    clamp_edge_det #(.HS_ACTIVE_HIGH(HS_ACTIVE_HIGH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_in (hsync_in),
        .trail_o  (trail_w)
    );

    clamp_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .trail_i (trail_w),
        .place_i (place_cfg),
        .dur_i   (dur_cfg),
        .clamp_o (clamp_int_w)
    );

    clamp_out_sel u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_mode     (ext_mode),
        .ext_clamp_in (ext_clamp_in),
        .int_clamp    (clamp_int_w),
        .clamp_out    (clamp_out)
    );
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
// Property checker for clamp_pulse_gen, attached with bind.
module clamp_pulse_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trail,
    input logic             clamp_int,
    input logic [CNT_W-1:0] place_cfg,
    input logic             ext_mode,
    input logic             ext_clamp_in,
    input logic             clamp_out
);
    localparam int MAX_LEN = (1 << CNT_W) - 1;

    logic           past_ok;
    logic [CNT_W:0] run_len;

    // Marks that one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Length of the current internal pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                       run_len <= '0;
        else if (!clamp_int)              run_len <= '0;
        else if (run_len != {(CNT_W+1){1'b1}}) run_len <= run_len + 1'b1;
    end

    assert_ext_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ext_mode) |-> (clamp_out == $past(ext_clamp_in)));

    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= (CNT_W+1)'(MAX_LEN));

    assert_zero_place_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trail && place_cfg == '0) |=> clamp_int);

    assert_wait_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trail && place_cfg != '0) |=> !clamp_int);
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trail        (trail_w),
    .clamp_int    (clamp_int_w),
    .place_cfg    (place_cfg),
    .ext_mode     (ext_mode),
    .ext_clamp_in (ext_clamp_in),
    .clamp_out    (clamp_out)
);

// File: tb/tb_clamp_pulse_gen.sv
module tb_clamp_pulse_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic [7:0] place_cfg = 8'd0;
    logic [7:0] dur_cfg = 8'd1;
    logic       ext_mode = 1'b0;
    logic       ext_clamp_in = 1'b0;
    logic       clamp_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_hs1 = 0, m_hs2 = 0;
    int m_active = 0, m_t = 0, m_p = 0, m_d = 1;
    int m_ext = 0;
    int m_int = 0;

    always #2.5 clk = ~clk;

    clamp_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in),
        .place_cfg(place_cfg), .dur_cfg(dur_cfg),
        .ext_mode(ext_mode), .ext_clamp_in(ext_clamp_in),
        .clamp_out(clamp_out)
    );

    // Behavioural model updated on each edge, compared 1 ns later.
    always @(posedge clk) begin
        int exp_v;
        if (!rst_n) begin
            m_hs1 = 0; m_hs2 = 0; m_active = 0; m_t = 0; m_ext = 0;
        end else begin
            if (m_hs2 == 1 && m_hs1 == 0) begin
                m_active = 1; m_t = 0;
                m_p = int'(place_cfg);
                m_d = (dur_cfg == 0) ? 1 : int'(dur_cfg);
            end else if (m_active != 0) begin
                m_t = m_t + 1;
            end
            if (m_active != 0 && m_t >= m_p + m_d) m_active = 0;
            m_hs2 = m_hs1;
            m_hs1 = int'(hsync_in);
            m_ext = int'(ext_clamp_in);
        end
        m_int = (m_active != 0 && m_t >= m_p && m_t < m_p + m_d) ? 1 : 0;
        #1;
        exp_v = (rst_n && ext_mode) ? m_ext : (rst_n ? m_int : 0);
        if (!done) begin
            n_cmp++;
            if (int'(clamp_out) != exp_v) begin
                n_bad++;
                $display("FAIL %s t=%0t clamp_out actual=%0d expected=%0d",
                         cur_tag, $time, clamp_out, exp_v);
            end
        end
    end

    task automatic run_line(input int hs_len, input int gap);
        hsync_in = 1'b1;
        repeat (hs_len) @(negedge clk);
        hsync_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic set_cfg(input int p, input int d, input string tag);
        place_cfg = 8'(p);
        dur_cfg   = 8'(d);
        cur_tag   = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: placement zero, length one
        set_cfg(0, 1, "R9");
        run_line(3, 8);
        // R3 and R4: placement 3, length 5
        set_cfg(3, 5, "R3");
        run_line(4, 15);
        set_cfg(7, 12, "R4");
        run_line(2, 30);
        // R5: zero length gives one pixel
        set_cfg(10, 0, "R5");
        run_line(5, 20);
        // R2: leading edge alone starts nothing; long sync
        set_cfg(2, 4, "R2");
        hsync_in = 1'b1;
        repeat (20) @(negedge clk);
        hsync_in = 1'b0;
        repeat (12) @(negedge clk);
        // R6: restart during the wait, then during the pulse
        set_cfg(6, 10, "R6");
        run_line(2, 4);
        run_line(2, 9);
        run_line(2, 25);
        // R4: maximum length and placement
        set_cfg(255, 255, "R4");
        run_line(3, 520);
        // R8: external input toggling in internal mode
        set_cfg(1, 3, "R8");
        for (int i = 0; i < 4; i++) begin
            hsync_in = 1'b1;
            ext_clamp_in = ~ext_clamp_in;
            repeat (2) @(negedge clk);
            hsync_in = 1'b0;
            for (int j = 0; j < 8; j++) begin
                ext_clamp_in = ((i + j) % 3) == 0;
                @(negedge clk);
            end
        end
        // R7: external mode passes the request, ignores internal timing
        set_cfg(0, 0, "R7");
        ext_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            hsync_in = 1'b1;
            repeat (2) @(negedge clk);
            hsync_in = 1'b0;
            for (int j = 0; j < 10; j++) begin
                ext_clamp_in = ((i * 7 + j) % 4) < 2;
                @(negedge clk);
            end
        end
        ext_mode = 1'b0;
        ext_clamp_in = 1'b0;
        set_cfg(4, 2, "R3");
        run_line(3, 12);
        // R1: reset again mid-sequence
        set_cfg(1, 20, "R1");
        run_line(2, 5);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule